// File: doc/BRIEF.md
# Reloadable Watch Interval Timer

This block is a periodic interval timer. A 6-bit down counter runs on one of four count clocks supplied from outside the block. A 2-bit field picks the count clock. Each time the counter wraps, it reloads from a programmable reload value, sets a sticky event flag and, if unmasked, raises an interrupt. A reload of N gives one event every N count-clock periods, and a reload of zero gives 64. Software sets it up through a small byte-wide register port on a bus clock that is asynchronous to all count clocks.

The enable bit travels into the count domain through a synchronizer. The run state of the counter returns as a read-only status bit, so software can see that the counter has really stopped before it starts it again. Counter events come back as a synchronized toggle. The live count can be read at any time. While the counter runs, software should read it twice and accept the value only when both reads agree.

Register map (selected by `reg_sel`): 0 = control, 1 = reload, 2 = live count (read-only), 3 = unused (reads 0). Control byte: bit 7 enable, bit 6 active status (read-only), bits 5:4 count-clock select, bit 1 interrupt enable, bit 0 event flag. Bits 3:2 are reserved. Reload byte: bits 5:0 reload value. Count byte: bits 5:0 live count.

Top module: `watch_ivl_timer`

## Requirements
- R1: After reset, the control, reload and count registers all read 0x00 and `irq` is low.
- R2: Reserved bits read 0 and ignore writes: control bits 6 and 3:2, reload bits 7:6, the whole count register, and select value 3.
- R3: While running with reload N in 1..63, the counter steps down by one on each rising edge of the selected count clock. On the edge where it holds 1 it reloads N, so events are exactly N count-clock periods apart.
- R4: A reload of 0 makes the counter run 63 down to 0 after loading 0, giving an event every 64 count-clock periods.
- R5: Control bits 5:4 select which of the four `cnt_clk_i` bits clocks the counter.
- R6: Each counter event sets the flag (control bit 0). Writing 0 to bit 0 clears it, writing 1 leaves it unchanged, and an event in the same cycle as a clear wins.
- R7: `irq` is high exactly when both the flag and the interrupt enable (control bit 1) are set. Setting the enable while the flag is already set raises `irq` in the bus cycle after the write.
- R8: A reload write while the counter runs does not change the period in progress. The new value takes effect at the next reload.
- R9: Clearing enable stops the counter, clears it to 0, and causes no further events.
- R10: The active bit (control bit 6) goes to 1 after enabling and back to 0 after disabling, each within a few count-clock periods.
- R11: On the first count edge after enable is seen, the counter loads the reload value. While running with N > 0, the live count read back lies in 1..N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several periods of the slowest count clock |
| cnt_clk_i | input | 4 | Four candidate count clocks |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, sampled on bus_clk |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request, flag AND interrupt enable |

## Verification
The bench measures event spacing in edges of the selected count clock. This catches a counter that declares underflow at zero (period N+1), one that treats a reload of zero as a stop (no events instead of 64-edge spacing), and one that ignores the clock-select field (wrong edge ratio). It rewrites the reload value just after an event. A design that loads the new value at once gives a short period in progress instead of one more old-length period. Flag tests write 1 to the flag, disable with the flag preserved, and turn on the mask over a pending flag. These catch a flag that clears on any write, one that is lost on stop, and an interrupt that waits for a fresh event.

// File: rtl/watch_ivl_pkg.sv
// Package: shared register-map constants for the watch interval timer.
// Assumes an 8-bit register port and a 2-bit clock select field.
package watch_ivl_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_ACT_BIT  = 6;
    localparam int CTRL_CS_LSB   = 4;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_FLAG_BIT = 0;

endpackage

// File: rtl/wit_sync.sv
// Module: multi-stage flop synchronizer for a W-bit vector.
// Assumes: multi-bit inputs are quasi-static or read twice by software;
// reset is synchronous active-low on the destination clock.
module wit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture flop of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Further settling flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wit_count_core.sv
// Module: count-domain part of the watch timer. Synchronizes enable and
// reload, runs the down counter, and toggles a flag on every reload event.
// Assumes: the reload value is stable near a reload edge (software changes
// it just after an event or while stopped); rst_n is held for several
// count-clock edges.
module wit_count_core #(
    parameter int CNT_W  = 6,
    parameter int STAGES = 2
) (
    input  logic             cnt_clk,
    input  logic             rst_n,
    input  logic             en_async,
    input  logic [CNT_W-1:0] reload_async,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running_q,
    output logic             uf_toggle_q,
    output logic             en_seen,
    output logic [CNT_W-1:0] reload_seen
);

    localparam logic [CNT_W-1:0] UF_VAL = CNT_W'(1);

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_RELOAD,
        ACT_DEC
    } cnt_act_e;

    cnt_act_e act;

    wit_sync #(.W(1), .STAGES(STAGES)) u_en_sync (
        .clk   (cnt_clk),
        .rst_n (rst_n),
        .d     (en_async),
        .q     (en_seen)
    );

    wit_sync #(.W(CNT_W), .STAGES(STAGES)) u_rl_sync (
        .clk   (cnt_clk),
        .rst_n (rst_n),
        .d     (reload_async),
        .q     (reload_seen)
    );

    // Pick the counter action for this count edge.
    always_comb begin
        if (!en_seen)              act = ACT_CLEAR;
        else if (!running_q)       act = ACT_LOAD;
        else if (cnt_q == UF_VAL)  act = ACT_RELOAD;
        else                       act = ACT_DEC;
    end

    // Counter, run state and event toggle.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            running_q   <= 1'b0;
            uf_toggle_q <= 1'b0;
        end else begin
            case (act)
                ACT_CLEAR: begin
                    cnt_q     <= '0;
                    running_q <= 1'b0;
                end
                ACT_LOAD: begin
                    cnt_q     <= reload_seen;
                    running_q <= 1'b1;
                end
                ACT_RELOAD: begin
                    cnt_q       <= reload_seen;
                    uf_toggle_q <= ~uf_toggle_q;
                end
                default: cnt_q <= cnt_q - 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/wit_bus_regs.sv
// Module: bus-domain register file of the watch timer. Holds enable, clock
// select, interrupt enable, reload value and the sticky flag; brings back
// run state, live count and event toggle through synchronizers.
// Assumes: clock select is only changed while the counter is stopped.
module wit_bus_regs #(
    parameter int CNT_W  = 6,
    parameter int CS_W   = 2,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              en_q,
    output logic [CS_W-1:0]   cs_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              flag_q,
    output logic              uf_pulse,
    input  logic              run_async,
    input  logic [CNT_W-1:0]  cnt_async,
    input  logic              tog_async
);

    import watch_ivl_pkg::*;

    logic             ie_q;
    logic             run_s;
    logic [CNT_W-1:0] cnt_s;
    logic             tog_s;
    logic             tog_prev_q;
    logic             wr_ctrl;
    logic             wr_reload;
    logic             unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_reload    = reg_wr && (reg_sel == SEL_RELOAD);
    assign unused_wbits = ^{reg_wdata[DATA_W-1:CNT_W], reg_wdata[CTRL_ACT_BIT],
                            reg_wdata[CTRL_CS_LSB-1:CTRL_IE_BIT+1]};

    wit_sync #(.W(1), .STAGES(STAGES)) u_run_sync (
        .clk (clk), .rst_n (rst_n), .d (run_async), .q (run_s)
    );

    wit_sync #(.W(CNT_W), .STAGES(STAGES)) u_cnt_sync (
        .clk (clk), .rst_n (rst_n), .d (cnt_async), .q (cnt_s)
    );

    wit_sync #(.W(1), .STAGES(STAGES)) u_tog_sync (
        .clk (clk), .rst_n (rst_n), .d (tog_async), .q (tog_s)
    );

    // Edge of the returned toggle marks one counter event.
    assign uf_pulse = tog_s ^ tog_prev_q;

    // Toggle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_prev_q <= 1'b0;
        else        tog_prev_q <= tog_s;
    end

    // Writable control fields and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            cs_q     <= '0;
            ie_q     <= 1'b0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= reg_wdata[CTRL_EN_BIT];
                cs_q <= reg_wdata[CTRL_CS_LSB +: CS_W];
                ie_q <= reg_wdata[CTRL_IE_BIT];
            end
            if (wr_reload) reload_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Sticky event flag: set by events, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  flag_q <= 1'b0;
        else if (uf_pulse)                           flag_q <= 1'b1;
        else if (wr_ctrl && !reg_wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
    end

    assign irq = flag_q & ie_q;

    // Read data selection.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CTRL_EN_BIT]              = en_q;
                reg_rdata[CTRL_ACT_BIT]             = run_s;
                reg_rdata[CTRL_CS_LSB +: CS_W]      = cs_q;
                reg_rdata[CTRL_IE_BIT]              = ie_q;
                reg_rdata[CTRL_FLAG_BIT]            = flag_q;
            end
            SEL_RELOAD: reg_rdata[CNT_W-1:0] = reload_q;
            SEL_COUNT:  reg_rdata[CNT_W-1:0] = cnt_s;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/watch_ivl_timer.sv
// Module: top of the watch interval timer. Selects the count clock and ties
// the bus-domain registers to the count-domain core.
// Assumes: count clocks are free-running, slower than bus_clk, and only
// switched while the counter is stopped.
module watch_ivl_timer #(
    parameter int CNT_W       = 6,
    parameter int NUM_CLK     = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               bus_clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] cnt_clk_i,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);

    localparam int CS_W = $clog2(NUM_CLK);

    logic             cnt_clk;
    logic             en_q;
    logic [CS_W-1:0]  cs_q;
    logic [CNT_W-1:0] reload_q;
    logic             flag_q;
    logic             uf_pulse;
    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic             uf_toggle_q;
    logic             en_seen;
    logic [CNT_W-1:0] reload_seen;

    // Count clock selection.
    assign cnt_clk = cnt_clk_i[cs_q];

    wit_bus_regs #(
        .CNT_W (CNT_W), .CS_W (CS_W), .DATA_W (DATA_W), .STAGES (SYNC_STAGES)
    ) u_regs (
        .clk       (bus_clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .en_q      (en_q),
        .cs_q      (cs_q),
        .reload_q  (reload_q),
        .flag_q    (flag_q),
        .uf_pulse  (uf_pulse),
        .run_async (running_q),
        .cnt_async (cnt_q),
        .tog_async (uf_toggle_q)
    );

    wit_count_core #(.CNT_W (CNT_W), .STAGES (SYNC_STAGES)) u_core (
        .cnt_clk      (cnt_clk),
        .rst_n        (rst_n),
        .en_async     (en_q),
        .reload_async (reload_q),
        .cnt_q        (cnt_q),
        .running_q    (running_q),
        .uf_toggle_q  (uf_toggle_q),
        .en_seen      (en_seen),
        .reload_seen  (reload_seen)
    );

endmodule

// File: rtl/watch_ivl_timer_chk.sv
// Module: assertion checker for the watch interval timer, bound to the top.
// Assumes: rst_n low disables all properties.
module watch_ivl_timer_chk #(
    parameter int CNT_W = 6
) (
    input logic             bus_clk,
    input logic             cnt_clk,
    input logic             rst_n,
    input logic             en_seen,
    input logic [CNT_W-1:0] reload_seen,
    input logic [CNT_W-1:0] cnt_q,
    input logic             running_q,
    input logic             flag_q,
    input logic             uf_pulse,
    input logic             reg_wr,
    input logic [1:0]       reg_sel,
    input logic [7:0]       reg_wdata
);

    p_stop_clears_r9: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        !en_seen |=> (cnt_q == '0 && !running_q));

    p_step_down_r3: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (en_seen && running_q && cnt_q > CNT_W'(1)) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    p_reload_at_one_r3: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (en_seen && running_q && cnt_q == CNT_W'(1)) |=> (cnt_q == $past(reload_seen)));

    p_wrap_from_zero_r4: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (en_seen && running_q && cnt_q == '0) |=> (cnt_q == '1));

    p_first_load_r11: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (en_seen && !running_q) |=> (running_q && cnt_q == $past(reload_seen)));

    p_event_sets_flag_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        uf_pulse |=> flag_q);

    p_no_spurious_flag_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (!flag_q && !uf_pulse) |=> !flag_q);

    p_clear_flag_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !reg_wdata[0] && !uf_pulse) |=> !flag_q);

endmodule

bind watch_ivl_timer watch_ivl_timer_chk #(.CNT_W (CNT_W)) u_chk (
    .bus_clk     (bus_clk),
    .cnt_clk     (cnt_clk),
    .rst_n       (rst_n),
    .en_seen     (en_seen),
    .reload_seen (reload_seen),
    .cnt_q       (cnt_q),
    .running_q   (running_q),
    .flag_q      (flag_q),
    .uf_pulse    (uf_pulse),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata)
);

// File: tb/watch_ivl_timer_tb.sv
module watch_ivl_timer_tb;

    logic       bus_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [3:0] cclk    = 4'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr  = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    int edges [4] = '{0, 0, 0, 0};

    always #2.5 bus_clk = ~bus_clk;
    always #25  cclk[0] = ~cclk[0];
    always #35  cclk[1] = ~cclk[1];
    always #45  cclk[2] = ~cclk[2];
    always #55  cclk[3] = ~cclk[3];

    always @(posedge cclk[0]) edges[0] = edges[0] + 1;
    always @(posedge cclk[1]) edges[1] = edges[1] + 1;
    always @(posedge cclk[2]) edges[2] = edges[2] + 1;
    always @(posedge cclk[3]) edges[3] = edges[3] + 1;

    watch_ivl_timer u_dut (
        .bus_clk   (bus_clk),
        .rst_n     (rst_n),
        .cnt_clk_i (cclk),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge bus_clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge bus_clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] data);
        @(negedge bus_clk);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    // Stable read of the live count: two equal reads in a row.
    task automatic rd_count(output logic [7:0] data);
        logic [7:0] a;
        logic [7:0] b;
        a = 8'hFF;
        for (int i = 0; i < 20; i++) begin
            rd(2'd2, b);
            if (a == b) break;
            a = b;
        end
        data = b;
    endtask

    // Wait for irq, note the selected clock's edge count, then clear the flag.
    task automatic wait_ev(input int cs, input logic [7:0] keep, output int e);
        int n;
        n = 0;
        e = -1;
        while (n < 20000) begin
            @(negedge bus_clk);
            if (irq) break;
            n++;
        end
        if (irq) e = edges[cs];
        else chk(1'b0, "timeout waiting for event", 0, 1);
        wr(2'd0, keep);
    endtask

    // Disable with flag preserved, wait until active reads 0.
    task automatic stop_timer(input logic [7:0] ctrl_off, input string tag);
        logic [7:0] v;
        wr(2'd0, ctrl_off);
        v = 8'h40;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, v);
            if (!v[6]) break;
        end
        chk(v[6] == 1'b0, tag, int'(v[6]), 0);
        #300;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk(v == 8'h00, "R1 control after reset", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 reload after reset", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 count after reset", v, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk(v == 8'h3F, "R2 reload upper bits", v, 8'h3F);
        wr(2'd0, 8'h4C);
        rd(2'd0, v); chk(v == 8'h00, "R2 control reserved and status bits", v, 0);
        wr(2'd2, 8'h15);
        rd(2'd2, v); chk(v == 8'h00, "R2 count write ignored", v, 0);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk(v == 8'h00, "R2 unused select", v, 0);
        rd(2'd0, v); chk(v == 8'h00, "R2 select 3 write left control", v, 0);
    endtask

    task automatic t_basic_period();
        logic [7:0] v;
        int e1, e2, e3;
        wr(2'd1, 8'd5);
        wr(2'd0, 8'h82);
        v = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, v);
            if (v[6]) break;
        end
        chk(v[6] == 1'b1, "R10 active after enable", v[6], 1);
        wait_ev(0, 8'h82, e1);
        wait_ev(0, 8'h82, e2);
        chk(e2 - e1 == 5, "R3 period reload 5", e2 - e1, 5);
        rd_count(v);
        chk(v >= 8'd1 && v <= 8'd5, "R11 live count in 1..5", v, 3);
        wait_ev(0, 8'h82, e3);
        chk(e3 - e2 == 5, "R3 second period reload 5", e3 - e2, 5);
    endtask

    task automatic t_reload_change();
        int e1, e2, e3;
        wait_ev(0, 8'h82, e1);
        wr(2'd1, 8'd9);
        wait_ev(0, 8'h82, e2);
        chk(e2 - e1 == 5, "R8 period in progress keeps old reload", e2 - e1, 5);
        wait_ev(0, 8'h82, e3);
        chk(e3 - e2 == 9, "R8 new reload at next reload", e3 - e2, 9);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        stop_timer(8'h03, "R10 active clears after disable");
        rd_count(v);
        chk(v == 8'h00, "R9 count cleared on stop", v, 0);
        wr(2'd0, 8'h02);
        #2000;
        rd(2'd0, v);
        chk(v[0] == 1'b0, "R9 no event after stop", v[0], 0);
        chk(irq == 1'b0, "R9 irq stays low after stop", irq, 0);
    endtask

    task automatic t_zero_reload();
        int e1, e2;
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h92);
        wait_ev(1, 8'h92, e1);
        wait_ev(1, 8'h92, e2);
        chk(e2 - e1 == 64, "R4 reload 0 gives 64", e2 - e1, 64);
        stop_timer(8'h13, "R10 active clears after stop");
    endtask

    task automatic t_clksel();
        int e1, e2;
        wr(2'd1, 8'd3);
        wr(2'd0, 8'hB2);
        wait_ev(3, 8'hB2, e1);
        wait_ev(3, 8'hB2, e2);
        chk(e2 - e1 == 3, "R5 clock select 3 period", e2 - e1, 3);
        stop_timer(8'h33, "R10 active clears after stop sel 3");
        wr(2'd0, 8'h02);
    endtask

    task automatic t_flag();
        logic [7:0] v;
        wr(2'd0, 8'h03);
        #1;
        chk(irq == 1'b0, "R6 writing 1 to clear flag does not set it", irq, 0);
        wr(2'd1, 8'd1);
        wr(2'd0, 8'h80);
        #1000;
        stop_timer(8'h01, "R10 active clears before flag test");
        rd(2'd0, v);
        chk(v[0] == 1'b1, "R6 flag sticky after stop", v[0], 1);
        chk(irq == 1'b0, "R7 irq masked with enable 0", irq, 0);
        wr(2'd0, 8'h01);
        rd(2'd0, v);
        chk(v[0] == 1'b1, "R6 writing 1 keeps flag", v[0], 1);
        wr(2'd0, 8'h03);
        chk(irq == 1'b1, "R7 irq on enabling over pending flag", irq, 1);
        wr(2'd0, 8'h02);
        rd(2'd0, v);
        chk(v[0] == 1'b0, "R6 writing 0 clears flag", v[0], 0);
        chk(irq == 1'b0, "R7 irq drops with flag", irq, 0);
    endtask

    initial begin
        repeat (60) @(posedge bus_clk);
        @(negedge bus_clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_basic_period();
        t_reload_change();
        t_disable();
        t_zero_reload();
        t_clksel();
        t_flag();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule